// File: doc/BRIEF.md
# USB Endpoint Control and Status Register

This block is the control and status word for one endpoint of a full-speed USB device controller. Software reaches it over a 16-bit register bus. The serial-interface side reports finished transactions through single-cycle event strobes. The word holds the endpoint address, the transfer type, the double-buffer kind bit, a two-bit handshake status for each direction, a data-toggle bit for each direction, a completion flag for each direction, and a read-only flag for SETUP packets.

Each field has its own write rule. The handshake status bits and the toggle bits invert wherever software writes a 1. The completion flags clear only where software writes a 0. Address, type and kind are plain storage. Software therefore reads the word, XORs in the bits it wants to change, writes ones over the flags it wants to keep, and writes the result back.

Each direction is driven by a four-state handshake machine. Its states are DISABLED, STALL, NAK and VALID. Transitions:
- Software flip: the next state is the current state XOR the written field. Any of the four states can reach any other this way.
- Completion: VALID moves to NAK on a transfer-done strobe when the endpoint is single-buffered.
- Hold: the state stays where it is on a transfer-done strobe when the endpoint is isochronous, or bulk with the kind bit set.
- Idle: no flip and no completion, so the state stays where it is.

In double-buffered mode, software uses the toggle bit of the opposite direction as its buffer pointer.

Top module: `usb_ep_csr`

## Requirements
- R1: Bits [2:0] (endpoint address), [12:11] (type: 00 bulk, 01 control, 10 isochronous, 11 interrupt) and [13] (kind) load the written value on a bus write and read back from the next cycle.
- R2: The RX status is bits [4:3] and the TX status is bits [8:7], each encoded 00 DISABLED, 01 STALL, 10 NAK, 11 VALID (bit 3 and bit 7 are the low bits). A written 1 inverts the matching status bit and a written 0 leaves it unchanged.
- R3: The RX toggle (bit 5) and the TX toggle (bit 9) invert when a 1 is written to them and are unchanged when a 0 is written.
- R4: The RX completion flag (bit 6) and the TX completion flag (bit 10) clear when a 0 is written to them and are unchanged when a 1 is written.
- R5: When the stored type is isochronous, or bulk with kind set, a transfer-done strobe sets that direction's flag and inverts its toggle but leaves its status unchanged.
- R6: On a TX done strobe for a single-buffered endpoint, the TX flag is set and the TX toggle inverts. A TX status of VALID becomes NAK, and any other TX status is unchanged.
- R7: On an RX done strobe for a single-buffered endpoint, the RX flag is set and the RX toggle inverts. An RX status of VALID becomes NAK, and any other RX status is unchanged.
- R8: On each RX done strobe, bit 14 takes the value of the setup qualifier. Bus writes do not change bit 14, and bit 15 always reads 0.
- R9: A synchronous reset clears the whole word to 0, which leaves both directions DISABLED.
- R10: When a bus write and a done strobe fall in the same cycle, the write is applied first and the strobe's effect second, so the strobe's flag set wins over a written 0.
- R11: The `tx_hs` and `rx_hs` outputs always equal the TX and RX status fields of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 16 | Bus write data |
| hw_tx_done | input | 1 | TX transaction completed (single cycle) |
| hw_rx_done | input | 1 | RX transaction completed (single cycle) |
| hw_rx_setup | input | 1 | Qualifies `hw_rx_done` as a SETUP transaction |
| rd_data | output | 16 | Current register word |
| tx_hs | output | 2 | TX handshake status |
| rx_hs | output | 2 | RX handshake status |

## Verification
Every result is due exactly one clock after its stimulus, because writes, strobes and reset all land in the same register stage. The bench drives one operation per cycle on the falling edge. It pushes the word its model predicts into a queue. A monitor pops that word two nanoseconds after the next rising edge and compares it with `rd_data`, `tx_hs` and `rx_hs`. Same-cycle collisions of a write and a strobe are driven as a single operation, so their combined result is checked in that same cycle.

// File: rtl/ep_csr_pkg.sv
package ep_csr_pkg;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned HS_W     = 2;
    localparam int unsigned TYPE_W   = 2;

    localparam int unsigned ADDR_LO  = 0;
    localparam int unsigned RX_HS_LO = ADDR_LO + ADDR_W;
    localparam int unsigned RX_TOG   = RX_HS_LO + HS_W;
    localparam int unsigned RX_FLAG  = RX_TOG + 1;
    localparam int unsigned TX_HS_LO = RX_FLAG + 1;
    localparam int unsigned TX_TOG   = TX_HS_LO + HS_W;
    localparam int unsigned TX_FLAG  = TX_TOG + 1;
    localparam int unsigned TYPE_LO  = TX_FLAG + 1;
    localparam int unsigned KIND_BIT = TYPE_LO + TYPE_W;
    localparam int unsigned SETUP_BIT = KIND_BIT + 1;
    localparam int unsigned DIRS     = 2;

    typedef enum logic [HS_W-1:0] {
        HS_DISABLED = 2'b00,
        HS_STALL    = 2'b01,
        HS_NAK      = 2'b10,
        HS_VALID    = 2'b11
    } hs_e;

    typedef enum logic [TYPE_W-1:0] {
        XF_BULK    = 2'b00,
        XF_CONTROL = 2'b01,
        XF_ISO     = 2'b10,
        XF_INTR    = 2'b11
    } xfer_e;

endpackage

// File: rtl/ep_hs_unit.sv
module ep_hs_unit
    import ep_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [HS_W-1:0] wr_flip,
    input  logic            wr_tog,
    input  logic            wr_flag,
    input  logic            hw_done,
    input  logic            hold_valid,
    output hs_e             hs_q,
    output logic            tog_q,
    output logic            flag_q
);

    hs_e  sw_st;
    hs_e  hs_d;
    logic tog_d;
    logic flag_d;

    // next-state process: software flip first, then completion event
    always_comb begin
        sw_st = hs_e'(hs_q ^ (wr_en ? wr_flip : {HS_W{1'b0}}));
        hs_d  = sw_st;
        if (hw_done && !hold_valid) begin
            unique case (sw_st)
                HS_VALID:    hs_d = HS_NAK;
                HS_NAK:      hs_d = HS_NAK;
                HS_STALL:    hs_d = HS_STALL;
                HS_DISABLED: hs_d = HS_DISABLED;
            endcase
        end
    end

    // toggle and flag follow the same write-then-event order
    always_comb begin
        tog_d  = tog_q ^ (wr_en & wr_tog) ^ hw_done;
        flag_d = (flag_q & ~(wr_en & ~wr_flag)) | hw_done;
    end

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q   <= HS_DISABLED;
            tog_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            hs_q   <= hs_d;
            tog_q  <= tog_d;
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/ep_cfg_unit.sv
module ep_cfg_unit
    import ep_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TYPE_W-1:0] wr_type,
    input  logic              wr_kind,
    input  logic              hw_rx_done,
    input  logic              hw_rx_setup,
    output logic [ADDR_W-1:0] addr_q,
    output xfer_e             type_q,
    output logic              kind_q,
    output logic              setup_q,
    output logic              hold_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            type_q  <= XF_BULK;
            kind_q  <= 1'b0;
            setup_q <= 1'b0;
        end else begin
            if (wr_en) begin
                addr_q <= wr_addr;
                type_q <= xfer_e'(wr_type);
                kind_q <= wr_kind;
            end
            if (hw_rx_done) begin
                setup_q <= hw_rx_setup;
            end
        end
    end

    // status is kept on completion for ping-pong bulk and isochronous
    always_comb begin
        unique case (type_q)
            XF_ISO:     hold_valid = 1'b1;
            XF_BULK:    hold_valid = kind_q;
            XF_CONTROL: hold_valid = 1'b0;
            XF_INTR:    hold_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/usb_ep_csr.sv
module usb_ep_csr
    import ep_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        hw_tx_done,
    input  logic        hw_rx_done,
    input  logic        hw_rx_setup,
    output logic [15:0] rd_data,
    output logic [1:0]  tx_hs,
    output logic [1:0]  rx_hs
);

    logic [ADDR_W-1:0] addr_q;
    xfer_e             type_q;
    logic              kind_q;
    logic              setup_q;
    logic              hold_valid;

    hs_e  hs_q   [DIRS];
    logic tog_q  [DIRS];
    logic flag_q [DIRS];

    ep_cfg_unit cfg_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_data[ADDR_LO +: ADDR_W]),
        .wr_type     (wr_data[TYPE_LO +: TYPE_W]),
        .wr_kind     (wr_data[KIND_BIT]),
        .hw_rx_done  (hw_rx_done),
        .hw_rx_setup (hw_rx_setup),
        .addr_q      (addr_q),
        .type_q      (type_q),
        .kind_q      (kind_q),
        .setup_q     (setup_q),
        .hold_valid  (hold_valid)
    );

    // direction 0 is RX, direction 1 is TX
    for (genvar d = 0; d < DIRS; d++) begin : g_dir
        localparam int unsigned HL = (d == 0) ? RX_HS_LO : TX_HS_LO;
        localparam int unsigned TG = (d == 0) ? RX_TOG   : TX_TOG;
        localparam int unsigned FL = (d == 0) ? RX_FLAG  : TX_FLAG;
        logic done;
        assign done = (d == 0) ? hw_rx_done : hw_tx_done;

        ep_hs_unit hs_i (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_en),
            .wr_flip    (wr_data[HL +: HS_W]),
            .wr_tog     (wr_data[TG]),
            .wr_flag    (wr_data[FL]),
            .hw_done    (done),
            .hold_valid (hold_valid),
            .hs_q       (hs_q[d]),
            .tog_q      (tog_q[d]),
            .flag_q     (flag_q[d])
        );
    end

    always_comb begin
        rd_data = '0;
        rd_data[ADDR_LO +: ADDR_W]  = addr_q;
        rd_data[RX_HS_LO +: HS_W]   = hs_q[0];
        rd_data[RX_TOG]             = tog_q[0];
        rd_data[RX_FLAG]            = flag_q[0];
        rd_data[TX_HS_LO +: HS_W]   = hs_q[1];
        rd_data[TX_TOG]             = tog_q[1];
        rd_data[TX_FLAG]            = flag_q[1];
        rd_data[TYPE_LO +: TYPE_W]  = type_q;
        rd_data[KIND_BIT]           = kind_q;
        rd_data[SETUP_BIT]          = setup_q;
    end

    assign tx_hs = hs_q[1];
    assign rx_hs = hs_q[0];

endmodule

// File: rtl/usb_ep_csr_chk.sv
module usb_ep_csr_chk
    import ep_csr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        hw_tx_done,
    input logic        hw_rx_done,
    input logic        hw_rx_setup,
    input logic [15:0] rd_data,
    input logic [1:0]  tx_hs,
    input logic [1:0]  rx_hs
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == 16'h0000)); // R9

    AST_TX_STATUS_FLIP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hw_tx_done) |=>
        (rd_data[TX_HS_LO +: HS_W] == ($past(rd_data[TX_HS_LO +: HS_W]) ^ $past(wr_data[TX_HS_LO +: HS_W])))); // R2

    AST_RX_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hw_rx_done) |=>
        (rd_data[RX_TOG] == ($past(rd_data[RX_TOG]) ^ $past(wr_data[RX_TOG])))); // R3

    AST_FLAG_KEEP_ON_ONE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[TX_FLAG] && !hw_tx_done) |=>
        (rd_data[TX_FLAG] == $past(rd_data[TX_FLAG]))); // R4

    AST_TX_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        hw_tx_done |=> rd_data[TX_FLAG]); // R6

    AST_RX_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        hw_rx_done |=> (rd_data[RX_FLAG] && (rd_data[SETUP_BIT] == $past(hw_rx_setup)))); // R7

    AST_SETUP_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        !hw_rx_done |=> $stable(rd_data[SETUP_BIT])); // R8

    AST_STATUS_PORTS: assert property (@(posedge clk) disable iff (rst)
        (tx_hs == rd_data[TX_HS_LO +: HS_W]) && (rx_hs == rd_data[RX_HS_LO +: HS_W])); // R11

endmodule

bind usb_ep_csr usb_ep_csr_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .hw_tx_done  (hw_tx_done),
    .hw_rx_done  (hw_rx_done),
    .hw_rx_setup (hw_rx_setup),
    .rd_data     (rd_data),
    .tx_hs       (tx_hs),
    .rx_hs       (rx_hs)
);

// File: tb/usb_ep_csr_tb_top.sv
module usb_ep_csr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        hw_tx_done = 1'b0;
    logic        hw_rx_done = 1'b0;
    logic        hw_rx_setup = 1'b0;
    logic [15:0] rd_data;
    logic [1:0]  tx_hs;
    logic [1:0]  rx_hs;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = '0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] word;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    usb_ep_csr dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .hw_tx_done(hw_tx_done), .hw_rx_done(hw_rx_done), .hw_rx_setup(hw_rx_setup),
        .rd_data(rd_data), .tx_hs(tx_hs), .rx_hs(rx_hs)
    );

    // reference of the register word, written from the requirements
    function automatic logic [15:0] next_word(input logic [15:0] m, input logic we,
                                              input logic [15:0] wd, input logic txd,
                                              input logic rxd, input logic stp);
        logic [15:0] r;
        logic hold;
        r = m;
        hold = (m[12:11] == 2'b10) || ((m[12:11] == 2'b00) && m[13]);
        if (we) begin
            r[2:0]   = wd[2:0];
            r[13:11] = wd[13:11];
            r[4:3]   = r[4:3] ^ wd[4:3];
            r[8:7]   = r[8:7] ^ wd[8:7];
            r[5]     = r[5] ^ wd[5];
            r[9]     = r[9] ^ wd[9];
            if (!wd[6])  r[6]  = 1'b0;
            if (!wd[10]) r[10] = 1'b0;
        end
        if (txd) begin
            r[10] = 1'b1;
            r[9]  = ~r[9];
            if (!hold && r[8:7] == 2'b11) r[8:7] = 2'b10;
        end
        if (rxd) begin
            r[6]  = 1'b1;
            r[5]  = ~r[5];
            if (!hold && r[4:3] == 2'b11) r[4:3] = 2'b10;
            r[14] = stp;
        end
        return r;
    endfunction

    // driver: one operation per cycle, expectation pushed to scoreboard
    task automatic drive_op(input logic rs, input logic we, input logic [15:0] wd,
                            input logic txd, input logic rxd, input logic stp,
                            input string tag);
        item_t it;
        @(negedge clk);
        rst = rs; wr_en = we; wr_data = wd;
        hw_tx_done = txd; hw_rx_done = rxd; hw_rx_setup = stp;
        model = rs ? 16'h0000 : next_word(model, we, wd, txd, rxd, stp);
        it.word = model;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    // monitor: results are due one clock after the driving edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (rd_data !== it.word) begin
                    errors++;
                    $display("FAIL %s word actual %h expected %h", it.tag, rd_data, it.word);
                end
                checks++;
                if (tx_hs !== it.word[8:7] || rx_hs !== it.word[4:3]) begin
                    errors++;
                    $display("FAIL R11 (%s) tx/rx status actual %b/%b expected %b/%b",
                             it.tag, tx_hs, rx_hs, it.word[8:7], it.word[4:3]);
                end
            end
        end
    end

    initial begin
        drive_op(1, 0, 16'h0000, 0, 0, 0, "R9 reset clears word");
        drive_op(0, 1, 16'h0DDD, 0, 0, 0, "R1 R2 load control addr 5, both to VALID");
        drive_op(0, 1, 16'h0C45, 0, 0, 0, "R2 zero bits keep status");
        drive_op(0, 0, 16'h0000, 1, 0, 0, "R6 tx done VALID to NAK");
        drive_op(0, 1, 16'h0C45, 0, 0, 0, "R4 write one keeps flag");
        drive_op(0, 0, 16'h0000, 0, 1, 1, "R7 R8 setup rx done");
        drive_op(0, 1, 16'h0C45, 0, 0, 0, "R8 write cannot clear setup");
        drive_op(0, 1, 16'h0805, 0, 0, 0, "R4 write zero clears flags");
        drive_op(0, 1, 16'h0E65, 0, 0, 0, "R3 toggles invert");
        drive_op(0, 1, 16'h0CC5, 0, 0, 0, "R2 tx NAK flipped to VALID");
        drive_op(0, 1, 16'h0805, 1, 0, 0, "R10 event flag beats write zero");
        drive_op(0, 0, 16'h0000, 0, 1, 0, "R7 R8 rx done on NAK, out data");
        drive_op(0, 1, 16'h24C3, 0, 0, 0, "R1 R2 bulk double buffer");
        drive_op(0, 0, 16'h0000, 1, 0, 0, "R5 double buffer keeps VALID");
        drive_op(0, 1, 16'h144A, 0, 0, 0, "R1 R2 iso, rx to VALID");
        drive_op(0, 0, 16'h0000, 0, 1, 0, "R5 iso keeps VALID");
        drive_op(0, 1, 16'h1C47, 0, 0, 0, "R1 interrupt type");
        drive_op(0, 0, 16'h0000, 1, 0, 0, "R6 interrupt tx done to NAK");
        drive_op(0, 1, 16'hFFFF, 0, 0, 0, "R8 top bits not writable");
        drive_op(0, 1, 16'h0000, 1, 1, 1, "R10 both events with write");
        drive_op(1, 1, 16'hFFFF, 1, 1, 1, "R9 reset overrides all");
        drive_op(0, 0, 16'h0000, 0, 0, 0, "R9 idle after reset");
        @(negedge clk);
        wr_en = 0; wr_data = '0; hw_tx_done = 0; hw_rx_done = 0; hw_rx_setup = 0;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule